// File: doc/BRIEF.md
# Scratch-Pad and Cached Region Request Router

This block sits between a processor's load/store port and two kinds of storage. It splits one word-addressed space at a fixed boundary. Requests below the boundary go to an on-chip scratch-pad array that always answers on the next cycle and never involves the cache. Requests at or above the boundary go to a small direct-mapped data cache. Behind the cache is a slow external memory port whose latency varies.

A read that misses in the cache fetches the whole line from external memory one word at a time, in rising offset order. It then installs the tag and returns the requested word. Stores to the cached region are written through to external memory. A store updates the cached copy only when the line is already present, so a store miss allocates nothing. Only one request is in flight at a time: the request-ready output stays low while a fill or a write-through is pending. Each response carries a hit flag that is set for scratch-pad accesses and for cache hits.

Top module: `spc_router`

## Requirements
- R1: An access with address below SPM_WORDS (default 32) is answered on the cycle after acceptance with rsp_hit = 1.
- R2: A scratch-pad access raises no external request.
- R3: A scratch-pad read returns the value most recently stored at that address. Every store response carries rsp_rdata = 0.
- R4: A read at or above the boundary whose line is present is answered on the cycle after acceptance with rsp_hit = 1, and it raises no external request.
- R5: A read miss issues exactly LINE_WORDS external reads, at line base, base+1 and so on in rising order. It then answers with rsp_hit = 0 and the requested word.
- R6: The cache is direct-mapped. The word offset is address bit 0, the line index is bits [2:1], and the tag is bits [7:3]. After a fill, the other words of that line hit. An access with the same index and a different tag evicts the line.
- R7: A store at or above the boundary makes exactly one external write with that address and data. On a hit it also updates the cached copy. Its response has rsp_hit equal to the tag match at acceptance.
- R8: A store miss does not allocate, so a later read of that address misses.
- R9: req_ready stays low from the acceptance of a miss or of a cached store until its response. A pending external request holds its address until it is accepted.
- R10: After reset, req_ready = 1, rsp_valid = 0, ext_req_valid = 0, and every cache line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Scratch-pad access or cache hit |
| rsp_rdata | output | DW | Load data (0 for stores) |
| ext_req_valid | output | 1 | External request present |
| ext_req_ready | input | 1 | External memory accepts request |
| ext_req_write | output | 1 | External request is a write |
| ext_req_addr | output | AW | External word address |
| ext_req_wdata | output | DW | External write data |
| ext_rsp_valid | input | 1 | External read data present |
| ext_rsp_rdata | input | DW | External read data |

## Verification
Every scratch-pad word is written with its own arithmetic pattern and read back. This tells the scratch-pad path apart from the cache path, and the bench watches the external port to confirm it stays quiet during those accesses. Sequential reads across the cached region alternate miss and hit within each two-word line. A revisit of the same eight words must hit throughout. A return to an evicted address separates hits from conflict misses. Stores to present and absent lines, plus a full sweep of the address space with random external latencies of 10 to 20 cycles, show the difference between write-through-with-update and no-allocate. The sweep also checks the fetch order and the hold of the ready signal.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FILL_REQ  = 2'd1,
        ST_FILL_WAIT = 2'd2,
        ST_WT_REQ    = 2'd3
    } ctrl_state_e;

    // Decode of one accepted request
    typedef struct packed {
        logic to_spm;
        logic is_write;
        logic tag_hit;
    } route_t;

    function automatic int unsigned tag_bits(int unsigned aw, int unsigned lines,
                                             int unsigned lw);
        return aw - $clog2(lines) - $clog2(lw);
    endfunction

endpackage

// File: rtl/spc_scratch.sv
module spc_scratch #(
    parameter int DW    = 16,
    parameter int WORDS = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem_q[idx] <= wdata;
            else    rdata      <= mem_q[idx];
        end
    end
endmodule

// File: rtl/spc_cache_store.sv
module spc_cache_store
    import spc_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int LINES = 4,
    parameter int LW    = 2,
    localparam int OFF_W = $clog2(LW),
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = tag_bits(AW, LINES, LW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_word,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          inst_en,
    input  logic [AW-1:0] inst_addr
);
    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [DW-1:0]    data_q [LINES][LW];

    logic [IDX_W-1:0] lk_idx, wr_idx, in_idx;
    logic [OFF_W-1:0] lk_off, wr_off;
    logic [TAG_W-1:0] lk_tag, in_tag;
    logic             unused_inst;

    assign lk_off  = lk_addr[OFF_W-1:0];
    assign lk_idx  = lk_addr[OFF_W +: IDX_W];
    assign lk_tag  = lk_addr[AW-1 -: TAG_W];
    assign wr_off  = wr_addr[OFF_W-1:0];
    assign wr_idx  = wr_addr[OFF_W +: IDX_W];
    assign in_idx  = inst_addr[OFF_W +: IDX_W];
    assign in_tag  = inst_addr[AW-1 -: TAG_W];
    assign unused_inst = ^inst_addr[OFF_W-1:0] ^ ^wr_addr[AW-1 -: TAG_W];

    assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_word = data_q[lk_idx][lk_off];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[l] <= 1'b0;
                tag_q[l] <= '0;
            end else if (inst_en && in_idx == IDX_W'(l)) begin
                vld_q[l] <= 1'b1;
                tag_q[l] <= in_tag;
            end
        end
        for (genvar w = 0; w < LW; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (wr_en && wr_idx == IDX_W'(l) && wr_off == OFF_W'(w))
                    data_q[l][w] <= wr_data;
            end
        end
    end

    // R6
    install_hit_chk: assert property (@(posedge clk) disable iff (rst)
        inst_en |=> vld_q[$past(in_idx)] && tag_q[$past(in_idx)] == $past(in_tag));
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
    import spc_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int SPM_WORDS = 32,
    parameter int LW        = 2,
    localparam int OFF_W    = $clog2(LW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          tag_hit,
    input  logic [DW-1:0] hit_word,
    output logic          spm_en,
    output logic          spm_we,
    output logic          cwr_en,
    output logic [AW-1:0] cwr_addr,
    output logic [DW-1:0] cwr_data,
    output logic          inst_en,
    output logic [AW-1:0] inst_addr,
    output logic          ext_req_valid,
    input  logic          ext_req_ready,
    output logic          ext_req_write,
    output logic [AW-1:0] ext_req_addr,
    output logic [DW-1:0] ext_req_wdata,
    input  logic          ext_rsp_valid,
    input  logic [DW-1:0] ext_rsp_rdata,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic          rsp_spm,
    output logic [DW-1:0] rsp_data
);
    localparam logic [AW:0]      BND      = (AW+1)'(SPM_WORDS);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LW - 1);

    ctrl_state_e      state_q;
    logic [AW-1:0]    lat_addr_q;
    logic [DW-1:0]    lat_wdata_q;
    logic             lat_hit_q;
    logic [OFF_W-1:0] beat_q;
    logic [DW-1:0]    fill_word_q;
    route_t           rt;
    logic             accept, fill_beat, last_beat, want_here;
    logic [AW-1:0]    fill_addr;

    assign rt.to_spm   = ({1'b0, req_addr} < BND);
    assign rt.is_write = req_write;
    assign rt.tag_hit  = tag_hit;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign fill_beat = (state_q == ST_FILL_WAIT) && ext_rsp_valid;
    assign last_beat = (beat_q == LAST_OFF);
    assign want_here = (beat_q == lat_addr_q[OFF_W-1:0]);
    assign fill_addr = {lat_addr_q[AW-1:OFF_W], beat_q};

    always_comb begin
        spm_en   = accept && rt.to_spm;
        spm_we   = rt.is_write;
        cwr_en   = 1'b0;
        cwr_addr = req_addr;
        cwr_data = req_wdata;
        if (fill_beat) begin
            cwr_en   = 1'b1;
            cwr_addr = fill_addr;
            cwr_data = ext_rsp_rdata;
        end else if (accept && !rt.to_spm && rt.is_write && rt.tag_hit) begin
            cwr_en = 1'b1;
        end
        inst_en   = fill_beat && last_beat;
        inst_addr = lat_addr_q;
    end

    always_comb begin
        ext_req_valid = (state_q == ST_FILL_REQ) || (state_q == ST_WT_REQ);
        ext_req_write = (state_q == ST_WT_REQ);
        ext_req_addr  = (state_q == ST_WT_REQ) ? lat_addr_q : fill_addr;
        ext_req_wdata = lat_wdata_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
            lat_hit_q   <= 1'b0;
            beat_q      <= '0;
            fill_word_q <= '0;
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_spm     <= 1'b0;
            rsp_data    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        lat_addr_q  <= req_addr;
                        lat_wdata_q <= req_wdata;
                        lat_hit_q   <= rt.tag_hit;
                        beat_q      <= '0;
                        if (rt.to_spm) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_spm   <= !rt.is_write;
                            rsp_data  <= '0;
                        end else if (rt.is_write) begin
                            state_q <= ST_WT_REQ;
                        end else if (rt.tag_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_spm   <= 1'b0;
                            rsp_data  <= hit_word;
                        end else begin
                            state_q <= ST_FILL_REQ;
                        end
                    end
                end
                ST_FILL_REQ: begin
                    if (ext_req_ready) state_q <= ST_FILL_WAIT;
                end
                ST_FILL_WAIT: begin
                    if (ext_rsp_valid) begin
                        if (want_here) fill_word_q <= ext_rsp_rdata;
                        if (last_beat) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b0;
                            rsp_spm   <= 1'b0;
                            rsp_data  <= want_here ? ext_rsp_rdata : fill_word_q;
                            state_q   <= ST_IDLE;
                        end else begin
                            beat_q  <= beat_q + 1'b1;
                            state_q <= ST_FILL_REQ;
                        end
                    end
                end
                ST_WT_REQ: begin
                    if (ext_req_ready) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= lat_hit_q;
                        rsp_spm   <= 1'b0;
                        rsp_data  <= '0;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1
    spm_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && rt.to_spm) |=> rsp_valid && rsp_hit);
    // R2
    spm_noext_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && rt.to_spm) |=> !ext_req_valid);
    // R4
    hit_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !rt.to_spm && !rt.is_write && rt.tag_hit) |=> rsp_valid && rsp_hit && !ext_req_valid);
    // R9
    miss_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !rt.to_spm && !(rt.is_write == 1'b0 && rt.tag_hit)) |=> !req_ready && !rsp_valid);
    // R9
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_req_valid && !ext_req_ready) |=> ext_req_valid && $stable(ext_req_addr) && $stable(ext_req_write));
    // R5
    miss_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> req_ready);
endmodule

// File: rtl/spc_router.sv
module spc_router
    import spc_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int SPM_WORDS = 32,
    parameter int LINES     = 4,
    parameter int LW        = 2,
    localparam int SPM_IW   = $clog2(SPM_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic          rsp_hit,
    output logic [DW-1:0] rsp_rdata,
    output logic          ext_req_valid,
    input  logic          ext_req_ready,
    output logic          ext_req_write,
    output logic [AW-1:0] ext_req_addr,
    output logic [DW-1:0] ext_req_wdata,
    input  logic          ext_rsp_valid,
    input  logic [DW-1:0] ext_rsp_rdata
);
    logic          spm_en, spm_we, rsp_spm;
    logic [DW-1:0] spm_rdata, rsp_data;
    logic          tag_hit;
    logic [DW-1:0] hit_word;
    logic          cwr_en, inst_en;
    logic [AW-1:0] cwr_addr, inst_addr;
    logic [DW-1:0] cwr_data;
    logic          unused_hi;

    assign unused_hi = ^req_addr[AW-1:SPM_IW];

    spc_scratch #(.DW(DW), .WORDS(SPM_WORDS)) u_spm (
        .clk   (clk),
        .en    (spm_en),
        .we    (spm_we),
        .idx   (req_addr[SPM_IW-1:0]),
        .wdata (req_wdata),
        .rdata (spm_rdata)
    );

    spc_cache_store #(.AW(AW), .DW(DW), .LINES(LINES), .LW(LW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_addr   (req_addr),
        .lk_hit    (tag_hit),
        .lk_word   (hit_word),
        .wr_en     (cwr_en),
        .wr_addr   (cwr_addr),
        .wr_data   (cwr_data),
        .inst_en   (inst_en),
        .inst_addr (inst_addr)
    );

    spc_ctrl #(.AW(AW), .DW(DW), .SPM_WORDS(SPM_WORDS), .LW(LW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .tag_hit       (tag_hit),
        .hit_word      (hit_word),
        .spm_en        (spm_en),
        .spm_we        (spm_we),
        .cwr_en        (cwr_en),
        .cwr_addr      (cwr_addr),
        .cwr_data      (cwr_data),
        .inst_en       (inst_en),
        .inst_addr     (inst_addr),
        .ext_req_valid (ext_req_valid),
        .ext_req_ready (ext_req_ready),
        .ext_req_write (ext_req_write),
        .ext_req_addr  (ext_req_addr),
        .ext_req_wdata (ext_req_wdata),
        .ext_rsp_valid (ext_rsp_valid),
        .ext_rsp_rdata (ext_rsp_rdata),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_spm       (rsp_spm),
        .rsp_data      (rsp_data)
    );

    assign rsp_rdata = rsp_spm ? spm_rdata : rsp_data;

    // R10
    idle_reset_chk: assert property (@(posedge clk) $past(rst) |-> req_ready && !rsp_valid && !ext_req_valid);
endmodule

// File: tb/spc_router_test.sv
module spc_router_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int P  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_hit;
    logic [DW-1:0] rsp_rdata;
    logic          ext_req_valid, ext_req_write;
    logic [AW-1:0] ext_req_addr;
    logic [DW-1:0] ext_req_wdata;
    logic          ext_req_ready = 1'b0, ext_rsp_valid = 1'b0;
    logic [DW-1:0] ext_rsp_rdata = '0;

    always #2 clk = ~clk;

    spc_router uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready),
        .ext_req_write(ext_req_write), .ext_req_addr(ext_req_addr),
        .ext_req_wdata(ext_req_wdata), .ext_rsp_valid(ext_rsp_valid),
        .ext_rsp_rdata(ext_rsp_rdata)
    );

    int total = 0, bad = 0;
    bit done = 0;
    logic [DW-1:0] ext_mem [256];
    logic [DW-1:0] spm_ref [P];
    bit            bvld [4];
    int            btag [4];
    int            ext_reads = 0, ext_writes = 0;
    int            rd_log [1024];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // External memory model: latency 10..20 cycles
    initial begin
        for (int i = 0; i < 256; i++) ext_mem[i] = 16'(i * 37 + 5);
        forever begin
            @(negedge clk);
            if (ext_req_valid) begin
                int a;
                a = int'(ext_req_addr);
                ext_req_ready = 1'b1;
                if (ext_req_write) begin
                    ext_mem[a] = ext_req_wdata;
                    ext_writes++;
                    @(negedge clk);
                    ext_req_ready = 1'b0;
                end else begin
                    rd_log[ext_reads % 1024] = a;
                    ext_reads++;
                    @(negedge clk);
                    ext_req_ready = 1'b0;
                    repeat (9 + (a % 11)) @(negedge clk);
                    ext_rsp_valid = 1'b1;
                    ext_rsp_rdata = ext_mem[a];
                    @(negedge clk);
                    ext_rsp_valid = 1'b0;
                end
            end
        end
    end

    task automatic acc(input bit wr, input int a, input logic [DW-1:0] wd);
        bit spm, exp_hit;
        int idx, tg, cycles, rd0, wr0, ready_bad;
        logic [DW-1:0] exp_data;
        spm = (a < P);
        idx = (a >> 1) & 3;
        tg  = a >> 3;
        exp_hit = spm || (bvld[idx] && btag[idx] == tg);
        exp_data = wr ? '0 : (spm ? spm_ref[a] : ext_mem[a]);
        rd0 = ext_reads;
        wr0 = ext_writes;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 1; ready_bad = 0;
        while (!rsp_valid) begin
            if (req_ready) ready_bad++;
            @(negedge clk);
            cycles++;
        end
        if (spm) begin
            chk(cycles == 1, "R1", "spm latency", cycles, 1);
            chk(rsp_hit == 1'b1, "R1", "spm hit flag", int'(rsp_hit), 1);
            chk(ext_reads == rd0 && ext_writes == wr0, "R2", "spm ext traffic",
                ext_reads + ext_writes - rd0 - wr0, 0);
            chk(rsp_rdata == exp_data, "R3", "spm data", int'(rsp_rdata), int'(exp_data));
            if (wr) spm_ref[a] = wd;
        end else if (wr) begin
            chk(ext_writes - wr0 == 1, "R7", "write-through count", ext_writes - wr0, 1);
            chk(ext_mem[a] == wd, "R7", "external word", int'(ext_mem[a]), int'(wd));
            chk(rsp_hit == exp_hit, "R7", "store hit flag", int'(rsp_hit), int'(exp_hit));
            chk(rsp_rdata == 0, "R3", "store rdata", int'(rsp_rdata), 0);
            chk(ready_bad == 0, "R9", "ready during write-through", ready_bad, 0);
        end else if (exp_hit) begin
            chk(cycles == 1, "R4", "hit latency", cycles, 1);
            chk(rsp_hit == 1'b1, "R4", "hit flag", int'(rsp_hit), 1);
            chk(ext_reads == rd0, "R4", "hit ext reads", ext_reads - rd0, 0);
            chk(rsp_rdata == exp_data, "R4", "hit data", int'(rsp_rdata), int'(exp_data));
        end else begin
            chk(rsp_hit == 1'b0, "R5", "miss flag", int'(rsp_hit), 0);
            chk(ext_reads - rd0 == 2, "R5", "fill reads", ext_reads - rd0, 2);
            chk(rd_log[rd0 % 1024] == (a & ~1) && rd_log[(rd0 + 1) % 1024] == (a | 1),
                "R5", "fill order", rd_log[rd0 % 1024], a & ~1);
            chk(cycles >= 21, "R5", "miss latency", cycles, 21);
            chk(rsp_rdata == exp_data, "R5", "miss data", int'(rsp_rdata), int'(exp_data));
            chk(ready_bad == 0, "R9", "ready during fill", ready_bad, 0);
            bvld[idx] = 1'b1;
            btag[idx] = tg;
        end
    endtask

    task automatic expect_hit(input int a, input bit h, input string req);
        bit spm, exp_hit;
        spm = (a < P);
        exp_hit = spm || (bvld[(a >> 1) & 3] && btag[(a >> 1) & 3] == (a >> 3));
        chk(exp_hit == h, req, "model hit expectation", int'(exp_hit), int'(h));
        acc(1'b0, a, '0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin bvld[i] = 0; btag[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state at the ports
        chk(req_ready == 1'b1, "R10", "req_ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", int'(rsp_valid), 0);
        chk(ext_req_valid == 1'b0, "R10", "ext_req_valid after reset", int'(ext_req_valid), 0);
        // R10: first cached read must miss
        acc(1'b0, 200, '0);
        chk(ext_reads == 2, "R10", "cold line fill reads", ext_reads, 2);

        // R1 R2 R3: fill and read back every scratch-pad word
        for (int a = 0; a < P; a++) acc(1'b1, a, 16'(a * 5 + 1));
        for (int a = P - 1; a >= 0; a--) acc(1'b0, a, '0);

        // R6: sequential walk, odd words hit after even miss
        for (int a = 32; a < 48; a++) expect_hit(a, a[0], "R6");
        for (int a = 40; a < 48; a++) expect_hit(a, 1'b1, "R6");
        expect_hit(32, 1'b0, "R6");   // evicted by 40
        // R7: store hit updates cached copy
        acc(1'b1, 33, 16'hBEEF);
        expect_hit(33, 1'b1, "R7");
        chk(rsp_rdata == 16'hBEEF, "R7", "updated cached word", int'(rsp_rdata), 16'hBEEF);
        // R8: store miss does not allocate
        acc(1'b1, 100, 16'h1234);
        expect_hit(100, 1'b0, "R8");
        chk(rsp_rdata == 16'h1234, "R8", "data after no-allocate", int'(rsp_rdata), 16'h1234);
        // boundary pair
        acc(1'b0, P - 1, '0);
        acc(1'b0, P, '0);
        acc(1'b0, 255, '0);
        acc(1'b0, 254, '0);
        // full sweep with interleaved stores
        for (int a = 0; a < 256; a++) begin
            acc(1'b0, a, '0);
            if (a % 7 == 3) acc(1'b1, 255 - a, 16'(a * 11 + 9));
        end
        for (int a = 255; a >= 0; a--) acc(1'b0, a, '0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule